// File: doc/BRIEF.md
# Mux-Scan Chain Test Sequencer

This block wraps a small sequential core whose flip-flops each sit behind a 2:1 input multiplexer. When scan enable is high, the flip-flops form one shift register. When it is low, each flip-flop takes the next-state value from the core's combinational logic. An on-chip sequencer runs the full scan test for every pattern. It shifts the initial state into the chain, holds the chain while the pattern's primary inputs are applied, gives one capture clock, and then shifts the response out while the next pattern's state shifts in.

Patterns arrive on a valid/ready stream. Each carries the initial chain state, the primary-input word and a last-pattern flag. The sequencer turns the state word into serial bits for the chain and rebuilds the serial response into a word. Results leave on a second valid/ready stream. Each result holds the captured chain state and the primary outputs latched on the capture clock. Both streams follow the usual rule: a transfer happens on a clock edge where valid and ready are both high. Valid and the data it qualifies stay stable until that edge. When the result consumer holds ready low, the chain waits with the next pattern applied and does not capture.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, pat_ready is 1 and res_valid, done and scan_en are all 0.
- R2: On accepting a pattern while idle or done, scan_en goes high for exactly CHAIN_LEN cycles. scan_si presents pat_state from bit CHAIN_LEN-1 down to bit 0, so bit k ends up in chain flip-flop k.
- R3: After a shift-in phase, scan_en is low and the chain holds its contents while the pattern's primary inputs are driven on core_pi. Exactly one capture cycle follows, and it happens only once the next pattern is accepted (or the current one is marked last) and the result slot is free.
- R4: The capture loads next state ns[i] = s[(i-1) mod CHAIN_LEN] ^ (i < IO_W ? pi[i] : 0), and the result's res_po[j] = s[j] ^ s[CHAIN_LEN-1-j] ^ pi[j]. Here s is the shifted-in state and pi is that pattern's input word.
- R5: After capture, scan_en is high for CHAIN_LEN cycles. scan_so delivers ns bit CHAIN_LEN-1 first, and res_state bit k equals ns bit k. The next pattern's state loads during these same cycles.
- R6: For a single last-flagged pattern, res_valid and done rise 2*CHAIN_LEN+2 cycles after the accepting clock edge.
- R7: While res_valid is 1 and res_ready is 0, res_valid, res_state and res_po stay unchanged.
- R8: pat_ready is 0 during the shift-in, capture and shift-out phases.
- R9: done rises in the same cycle as the result of the last-flagged pattern. It stays high with pat_ready high, and accepting a pattern from that state starts a new run.
- R10: Exactly one result is produced per accepted pattern, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_valid | input | 1 | Pattern stream valid |
| pat_ready | output | 1 | Pattern stream ready |
| pat_state | input | CHAIN_LEN | Initial chain state for the pattern |
| pat_pi | input | IO_W | Primary-input word for the pattern |
| pat_last | input | 1 | Marks the final pattern of a run |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_state | output | CHAIN_LEN | Captured chain state, rebuilt from the serial response |
| res_po | output | IO_W | Primary outputs latched on the capture clock |
| scan_en | output | 1 | Chain multiplexer select, high while shifting |
| scan_si | output | 1 | Serial bit driven into chain flip-flop 0 |
| scan_so | output | 1 | Serial bit from the last chain flip-flop |
| core_pi | output | IO_W | Primary inputs currently applied to the core |
| done | output | 1 | Run finished |

## Verification
With CHAIN_LEN = 8, a single pattern's serial input is due one bit per cycle, starting at the cycle after the accepting edge. scan_en drops at cycle CHAIN_LEN, capture happens at CHAIN_LEN+1, and the serial response runs from CHAIN_LEN+2. The result and done are due at 2*CHAIN_LEN+2. The bench counts falling edges from the accepting edge and compares each of these outputs at exactly its cycle. An exhaustive run then sends every state and input combination with an irregular result-ready pattern and a long stall. Handshakes are sampled on the falling edge and inputs change just after the rising edge, so each result is checked when it transfers and its stability is checked on every stalled cycle.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SHIFT_IN  = 3'd1,
    ST_APPLY     = 3'd2,
    ST_CAPTURE   = 3'd3,
    ST_SHIFT_OUT = 3'd4,
    ST_DONE      = 3'd5
  } seq_state_e;
endpackage

// File: rtl/scan_core.sv
module scan_core #(
  parameter int CHAIN_LEN = 8,
  parameter int IO_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 cap_en,
  input  logic                 scan_in,
  input  logic [IO_W-1:0]      pi,
  output logic                 scan_out,
  output logic [IO_W-1:0]      po
);
  logic [CHAIN_LEN-1:0] q;
  logic [CHAIN_LEN-1:0] d_scan;
  logic [CHAIN_LEN-1:0] d_func;

  // per-cell mux inputs: scan path from the neighbour, functional path from logic
  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign d_scan[i] = scan_in;
    end else begin : g_body
      assign d_scan[i] = q[i-1];
    end
    if (i < IO_W) begin : g_pi
      assign d_func[i] = q[(i+CHAIN_LEN-1)%CHAIN_LEN] ^ pi[i];
    end else begin : g_nopi
      assign d_func[i] = q[(i+CHAIN_LEN-1)%CHAIN_LEN];
    end
  end

  for (genvar j = 0; j < IO_W; j++) begin : g_po
    assign po[j] = q[j] ^ q[CHAIN_LEN-1-j] ^ pi[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q <= '0;
    else if (shift_en || cap_en) q <= shift_en ? d_scan : d_func;
  end

  assign scan_out = q[CHAIN_LEN-1];

  // R3: chain holds outside shift and capture cycles
  a_r3_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !cap_en) |=> $stable(q));
  // R3: shift and capture never coincide
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && cap_en));
endmodule

// File: rtl/scan_ser.sv
module scan_ser #(
  parameter int CHAIN_LEN = 8,
  parameter int IO_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [CHAIN_LEN-1:0] pat_state,
  input  logic                 shift_en,
  input  logic                 deser_en,
  input  logic                 po_ld,
  input  logic [IO_W-1:0]      po_in,
  input  logic                 res_set,
  input  logic                 res_ready,
  input  logic                 chain_out,
  output logic                 chain_in,
  output logic                 res_valid,
  output logic [CHAIN_LEN-1:0] res_state,
  output logic [IO_W-1:0]      res_po
);
  logic [CHAIN_LEN-1:0] sh_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_in <= '0;
    else if (ld)       sh_in <= pat_state;
    else if (shift_en) sh_in <= {sh_in[CHAIN_LEN-2:0], 1'b0};
  end
  assign chain_in = sh_in[CHAIN_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_state <= '0;
      res_po    <= '0;
      res_valid <= 1'b0;
    end else begin
      if (deser_en) res_state <= {res_state[CHAIN_LEN-2:0], chain_out};
      if (po_ld)    res_po    <= po_in;
      if (res_set)        res_valid <= 1'b1;
      else if (res_ready) res_valid <= 1'b0;
    end
  end

  // R7: a stalled result keeps its value and data
  a_r7_res_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_state) && $stable(res_po)));
  // R7: a new result is never set over a pending one
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    res_set |-> !res_valid);
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int IO_W      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pat_valid,
  input  logic            pat_last,
  input  logic [IO_W-1:0] pat_pi,
  input  logic            res_valid,
  input  logic            res_ready,
  output logic            pat_ready,
  output logic            ld,
  output logic            shift_en,
  output logic            cap_en,
  output logic            deser_en,
  output logic            res_set,
  output logic            done,
  output logic [IO_W-1:0] core_pi
);
  localparam int CW = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CHAIN_LEN - 1);

  seq_state_e      st, st_nx;
  logic [CW-1:0]   cnt;
  logic [IO_W-1:0] cur_pi, nxt_pi;
  logic            cur_last, nxt_last, tail;
  logic            in_idle, res_free, cnt_end, accept;

  assign in_idle  = (st == ST_IDLE) || (st == ST_DONE);
  assign res_free = !res_valid || res_ready;
  assign cnt_end  = (cnt == CNT_LAST);
  assign pat_ready = in_idle || (st == ST_APPLY && !cur_last && res_free);
  assign accept   = pat_valid && pat_ready;

  assign ld       = accept;
  assign shift_en = (st == ST_SHIFT_IN) || (st == ST_SHIFT_OUT);
  assign deser_en = (st == ST_SHIFT_OUT);
  assign cap_en   = (st == ST_CAPTURE);
  assign res_set  = (st == ST_SHIFT_OUT) && cnt_end;
  assign done     = (st == ST_DONE);
  assign core_pi  = cur_pi;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE, ST_DONE: if (accept) st_nx = ST_SHIFT_IN;
      ST_SHIFT_IN:      if (cnt_end) st_nx = ST_APPLY;
      ST_APPLY:         if (res_free && (cur_last || pat_valid)) st_nx = ST_CAPTURE;
      ST_CAPTURE:       st_nx = ST_SHIFT_OUT;
      ST_SHIFT_OUT:     if (cnt_end) st_nx = tail ? ST_DONE : ST_APPLY;
      default:          st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cur_pi   <= '0;
      nxt_pi   <= '0;
      cur_last <= 1'b0;
      nxt_last <= 1'b0;
      tail     <= 1'b0;
    end else begin
      st  <= st_nx;
      cnt <= (shift_en && !cnt_end) ? cnt + 1'b1 : '0;
      if (accept && in_idle) begin
        cur_pi   <= pat_pi;
        cur_last <= pat_last;
      end else if (accept) begin
        nxt_pi   <= pat_pi;
        nxt_last <= pat_last;
      end
      if (cap_en) begin
        tail     <= cur_last;
        cur_pi   <= nxt_pi;
        cur_last <= nxt_last;
      end
    end
  end

  // R3: capture lasts one cycle and is followed by shifting
  a_r3_cap_single: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAPTURE) |=> (st == ST_SHIFT_OUT));
  // R8: no pattern taken while the chain is busy
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT_IN || st == ST_SHIFT_OUT || st == ST_CAPTURE) |-> !pat_ready);
  // R2: shift counter stays inside the chain length
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST);
  // R9: done only after the last result has been raised
  a_r9_done_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(res_set));
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
  parameter int CHAIN_LEN = 8,
  parameter int IO_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pat_valid,
  output logic                 pat_ready,
  input  logic [CHAIN_LEN-1:0] pat_state,
  input  logic [IO_W-1:0]      pat_pi,
  input  logic                 pat_last,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [CHAIN_LEN-1:0] res_state,
  output logic [IO_W-1:0]      res_po,
  output logic                 scan_en,
  output logic                 scan_si,
  output logic                 scan_so,
  output logic [IO_W-1:0]      core_pi,
  output logic                 done
);
  logic            ld, shift_en, cap_en, deser_en, res_set;
  logic [IO_W-1:0] po;

  scan_sequencer #(.CHAIN_LEN(CHAIN_LEN), .IO_W(IO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_last(pat_last),
    .pat_pi(pat_pi), .res_valid(res_valid), .res_ready(res_ready),
    .pat_ready(pat_ready), .ld(ld), .shift_en(shift_en), .cap_en(cap_en),
    .deser_en(deser_en), .res_set(res_set), .done(done), .core_pi(core_pi)
  );

  scan_ser #(.CHAIN_LEN(CHAIN_LEN), .IO_W(IO_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .ld(ld), .pat_state(pat_state),
    .shift_en(shift_en), .deser_en(deser_en), .po_ld(cap_en), .po_in(po),
    .res_set(res_set), .res_ready(res_ready), .chain_out(scan_so),
    .chain_in(scan_si), .res_valid(res_valid), .res_state(res_state),
    .res_po(res_po)
  );

  scan_core #(.CHAIN_LEN(CHAIN_LEN), .IO_W(IO_W)) u_core (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cap_en(cap_en),
    .scan_in(scan_si), .pi(core_pi), .scan_out(scan_so), .po(po)
  );

  assign scan_en = shift_en;

  // R9: done never coincides with shifting
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scan_en);
endmodule

// File: tb/tb_scan_test_seq.sv
module tb_scan_test_seq;
  localparam int N  = 8;
  localparam int IO = 4;
  localparam int NPAT = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic pat_valid, pat_ready, pat_last, res_valid, res_ready;
  logic [N-1:0]  pat_state, res_state;
  logic [IO-1:0] pat_pi, res_po, core_pi;
  logic scan_en, scan_si, scan_so, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scan_test_seq #(.CHAIN_LEN(N), .IO_W(IO)) dut (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_state(pat_state), .pat_pi(pat_pi), .pat_last(pat_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_state(res_state),
    .res_po(res_po), .scan_en(scan_en), .scan_si(scan_si), .scan_so(scan_so),
    .core_pi(core_pi), .done(done)
  );

  function automatic logic [N-1:0] exp_ns(input logic [N-1:0] s, input logic [IO-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = s[(i+N-1)%N] ^ ((i < IO) ? p[i] : 1'b0);
    return r;
  endfunction

  function automatic logic [IO-1:0] exp_po(input logic [N-1:0] s, input logic [IO-1:0] p);
    logic [IO-1:0] r;
    for (int j = 0; j < IO; j++) r[j] = s[j] ^ s[N-1-j] ^ p[j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [N-1:0]  s0, ns0;
    logic [IO-1:0] p0;
    int pidx, ridx, xfer;
    bit hold;
    logic [N-1:0]  hold_st;
    logic [IO-1:0] hold_po;

    rst_n = 1'b0; pat_valid = 1'b0; pat_state = '0; pat_pi = '0;
    pat_last = 1'b0; res_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pat_ready == 1'b1, "R1 pat_ready", pat_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(done == 1'b0,      "R1 done", done, 0);
    chk(scan_en == 1'b0,   "R1 scan_en", scan_en, 0);

    // single last-flagged pattern, cycle-exact timing
    s0 = 8'hA5; p0 = 4'h3; ns0 = exp_ns(s0, p0);
    pat_valid = 1'b1; pat_state = s0; pat_pi = p0; pat_last = 1'b1;
    @(posedge clk);
    #1 pat_valid = 1'b0;
    for (int k = 0; k <= 2*N+2; k++) begin
      @(negedge clk);
      if (k < N) begin
        chk(scan_en == 1'b1, "R2 scan_en during shift-in", scan_en, 1);
        chk(scan_si == s0[N-1-k], "R2 scan_si order", scan_si, s0[N-1-k]);
        chk(pat_ready == 1'b0, "R8 busy in shift-in", pat_ready, 0);
      end else if (k <= N+1) begin
        chk(scan_en == 1'b0, "R3 scan_en low apply/capture", scan_en, 0);
        chk(core_pi == p0, "R3 core_pi applied", core_pi, p0);
      end else if (k <= 2*N+1) begin
        chk(scan_en == 1'b1, "R5 scan_en during shift-out", scan_en, 1);
        chk(scan_so == ns0[N-1-(k-N-2)], "R5 scan_so order", scan_so, ns0[N-1-(k-N-2)]);
        chk(res_valid == 1'b0, "R6 no early result", res_valid, 0);
      end else begin
        chk(res_valid == 1'b1, "R6 result at 2N+2", res_valid, 1);
        chk(done == 1'b1, "R9 done with last result", done, 1);
        chk(res_state == ns0, "R4 R5 res_state", res_state, ns0);
        chk(res_po == exp_po(s0, p0), "R4 res_po", res_po, exp_po(s0, p0));
        chk(pat_ready == 1'b1, "R9 ready when done", pat_ready, 1);
      end
    end
    @(posedge clk);
    #1;

    // exhaustive run from DONE with throttled result consumer
    pidx = 0; ridx = 0; hold = 0; hold_st = '0; hold_po = '0;
    pat_valid = 1'b1; pat_state = '0; pat_pi = '0; pat_last = 1'b0;
    while (ridx < NPAT) begin
      @(negedge clk);
      xfer = (pat_valid && pat_ready) ? 1 : 0;
      if (hold) begin
        chk(res_valid == 1'b1, "R7 valid held", res_valid, 1);
        chk(res_state == hold_st && res_po == hold_po, "R7 data held",
            {res_state, res_po}, {hold_st, hold_po});
      end
      if (res_valid && res_ready) begin
        chk(res_state == exp_ns(ridx[7:0], ridx[11:8]), "R10 R4 res_state",
            res_state, exp_ns(ridx[7:0], ridx[11:8]));
        chk(res_po == exp_po(ridx[7:0], ridx[11:8]), "R10 R4 res_po",
            res_po, exp_po(ridx[7:0], ridx[11:8]));
        if (ridx == NPAT-1) chk(done == 1'b1, "R9 done at final result", done, 1);
        else                chk(done == 1'b0, "R9 done not early", done, 0);
        ridx++;
      end
      hold = res_valid && !res_ready;
      hold_st = res_state; hold_po = res_po;
      @(posedge clk);
      #1;
      pidx += xfer;
      pat_valid = (pidx < NPAT);
      pat_state = pidx[7:0];
      pat_pi    = pidx[11:8];
      pat_last  = (pidx == NPAT-1);
      res_ready = ((cyc % 5) != 2) && !(cyc > 3000 && cyc < 3040);
    end
    @(negedge clk);
    chk(pidx == NPAT, "R10 all patterns accepted", pidx, NPAT);
    chk(done == 1'b1 && pat_ready == 1'b1, "R9 done holds", {done, pat_ready}, 2'b11);
    chk(res_valid == 1'b0, "R10 no extra result", res_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule